// File: doc/BRIEF.md
# Watchdog Reset Status Controller

This block pairs an 8-bit watchdog up-counter with a small control/status register. When the counter wraps from its all-ones value back to zero, the block raises an internal chip-reset pulse of fixed length. A sticky flag in the register records that the last chip reset came from the watchdog. A software-owned enable bit in the same register decides whether that pulse is also driven onto an active-low external reset output.

The flag and the output-enable bit are cleared only by the external pin reset, so software can tell after any chip reset whether the watchdog caused it. Clearing the flag is guarded. Software must first read the register while the flag is set, and its next write must then carry a 0 in the flag position. A plain read strobe and a plain byte write strobe form the register interface.

The controller is a four-state machine. `ST_IDLE` holds the counter at zero and moves to `ST_RUN` when the watchdog enable input is high. `ST_RUN` counts one step per clock. It returns to `ST_IDLE` if the enable drops, and it moves to `ST_RST` on overflow. `ST_RST` drives the chip reset for a fixed number of cycles and then moves to `ST_HOLD`. `ST_HOLD` models the cleared enable bit: it waits for the enable input to go low, then returns to `ST_IDLE`.

Top module: `wdt_rststat`

## Requirements
- R1: After the pin reset is released, `reg_rdata` reads 8'h3F, `chip_rst` is 0 and `ext_rst_n` is 1.
- R2: Register bits 5..0 always read as 1, whatever value is written.
- R3: Once `wd_en` is first sampled high in the idle state, the counter advances one step per clock. Overflow from 8'hFF to 8'h00 raises `chip_rst` on the 257th rising edge, counting that first sampling edge as edge 1.
- R4: `chip_rst` stays high for exactly 8 clock cycles, with the counter held at 0. After the pulse, the counter does not restart until `wd_en` has been seen low and then high again.
- R5: An overflow sets register bit 7, the watchdog-reset flag.
- R6: While `chip_rst` is high, `ext_rst_n` is 0 when register bit 6 (output enable) is 1. `ext_rst_n` stays 1 when bit 6 is 0.
- R7: Bits 7 and 6 keep their values through a watchdog-generated reset. Only the pin reset returns them to 0.
- R8: A write carrying 1 in bit 7 never sets the flag and never clears it. A write always loads bit 6 from write-data bit 6.
- R9: A write with 0 in bit 7 clears the flag only if a read strobe has returned bit 7 = 1 since the previous write. Every write disarms this qualifier.
- R10: If an overflow and a clearing write fall on the same clock edge, bit 7 ends up set.
- R11: Dropping `wd_en` during counting returns the counter to 0 with no reset. A later count then starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pin_rst_n | input | 1 | External pin reset, active low, asynchronous assert |
| wd_en | input | 1 | Watchdog enable level |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| chip_rst | output | 1 | Internal chip reset pulse, active high |
| ext_rst_n | output | 1 | External reset output, active low, gated by bit 6 |

## Verification
The overflow that sets the flag and a software write that would clear it can land on the same clock edge. The bench provokes this by arming the qualifier with a read early in a counting run. It then times a write of 0 so that the write strobe is sampled on exactly the 257th edge, the one that raises `chip_rst`. The collision is judged correct when `chip_rst` is high and bit 7 still reads 1 right after that edge. An earlier scenario shows that the same armed write, placed away from an overflow, does clear the flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int REG_W    = 8;
    localparam int FLAG_BIT = 7;
    localparam int OE_BIT   = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RST  = 2'd2,
        ST_HOLD = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic pin_rst_n,
    input  logic wd_en,
    output logic ovf,
    output logic chip_rst
);
    localparam int             PW      = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [PW-1:0]  PLS_END = PW'(PULSE_LEN - 1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    pls_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wd_en) state_d = ST_RUN;
            ST_RUN: begin
                if (!wd_en)               state_d = ST_IDLE;
                else if (cnt_q == CNT_MAX) state_d = ST_RST;
            end
            ST_RST:  if (pls_q == PLS_END) state_d = ST_HOLD;
            ST_HOLD: if (!wd_en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge pin_rst_n) begin
        if (!pin_rst_n) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    // counters
    always_ff @(posedge clk or negedge pin_rst_n) begin
        if (!pin_rst_n) begin
            cnt_q <= '0;
            pls_q <= '0;
        end else begin
            cnt_q <= (state_q == ST_RUN && wd_en) ? cnt_q + 1'b1 : '0;
            pls_q <= (state_q == ST_RST) ? pls_q + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        ovf      = (state_q == ST_RUN) && wd_en && (cnt_q == CNT_MAX);
        chip_rst = (state_q == ST_RST);
    end

    // R3: the reset pulse starts only from a counter at its top value
    p_ovf_from_max_r3: assert property (@(posedge clk) disable iff (!pin_rst_n)
        $rose(chip_rst) |-> $past(cnt_q) == CNT_MAX);

    // R4: the counter is held at zero while the pulse is active
    p_cnt_held_r4: assert property (@(posedge clk) disable iff (!pin_rst_n)
        chip_rst |-> cnt_q == '0);

    // R4: the pulse ends only after its full length
    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!pin_rst_n)
        $fell(chip_rst) |-> $past(pls_q) == PLS_END);

    // R11: the counter is zero whenever counting is not enabled
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!pin_rst_n)
        (state_q == ST_IDLE) |-> cnt_q == '0);
endmodule

// File: rtl/wdt_stat_reg.sv
module wdt_stat_reg
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             pin_rst_n,
    input  logic             ovf,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             oe
);
    logic flag_q, oe_q, armed_q;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[OE_BIT-1:0];

    always_ff @(posedge clk or negedge pin_rst_n) begin
        if (!pin_rst_n) begin
            flag_q  <= 1'b0;
            oe_q    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (ovf || reg_wr)          armed_q <= 1'b0;
            else if (reg_rd && flag_q)  armed_q <= 1'b1;

            if (reg_wr) oe_q <= reg_wdata[OE_BIT];

            if (ovf)
                flag_q <= 1'b1;
            else if (reg_wr && armed_q && !reg_wdata[FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata           = '1;
        reg_rdata[FLAG_BIT] = flag_q;
        reg_rdata[OE_BIT]   = oe_q;
        oe                  = oe_q;
    end

    // R5: an overflow sets the flag
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!pin_rst_n)
        ovf |=> flag_q);

    // R10: a write on the overflow edge cannot clear the flag
    p_collide_r10: assert property (@(posedge clk) disable iff (!pin_rst_n)
        (ovf && reg_wr) |=> flag_q);

    // R9: the flag falls only on an armed write of zero
    p_clear_armed_r9: assert property (@(posedge clk) disable iff (!pin_rst_n)
        $fell(flag_q) |-> $past(armed_q && reg_wr && !reg_wdata[FLAG_BIT]));

    // R7: the enable bit changes only on a write
    p_oe_hold_r7: assert property (@(posedge clk) disable iff (!pin_rst_n)
        !reg_wr |=> $stable(oe_q));
endmodule

// File: rtl/wdt_rststat.sv
module wdt_rststat
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 8
) (
    input  logic       clk,
    input  logic       pin_rst_n,
    input  logic       wd_en,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       chip_rst,
    output logic       ext_rst_n
);
    logic ovf;
    logic oe;

    wdt_ctrl #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_ctrl (
        .clk       (clk),
        .pin_rst_n (pin_rst_n),
        .wd_en     (wd_en),
        .ovf       (ovf),
        .chip_rst  (chip_rst)
    );

    wdt_stat_reg u_reg (
        .clk       (clk),
        .pin_rst_n (pin_rst_n),
        .ovf       (ovf),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .oe        (oe)
    );

    assign ext_rst_n = !(chip_rst && oe);

    // R6: the external output goes low only for an enabled reset pulse
    p_ext_gate_r6: assert property (@(posedge clk) disable iff (!pin_rst_n)
        !ext_rst_n |-> (chip_rst && reg_rdata[OE_BIT]));

    // R2: reserved bits read as ones
    p_reserved_r2: assert property (@(posedge clk) disable iff (!pin_rst_n)
        reg_rdata[5:0] == 6'h3F);
endmodule

// File: tb/wdt_rststat_tb.sv
`timescale 1ns/100ps
module wdt_rststat_tb;
    logic       clk = 1'b0;
    logic       pin_rst_n = 1'b0;
    logic       wd_en = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       chip_rst;
    logic       ext_rst_n;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    wdt_rststat u_dut (
        .clk       (clk),
        .pin_rst_n (pin_rst_n),
        .wd_en     (wd_en),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .chip_rst  (chip_rst),
        .ext_rst_n (ext_rst_n)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic bus_read(output logic [7:0] d);
        reg_rd = 1'b1;
        d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic bus_write(logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic pin_reset();
        pin_rst_n = 1'b0;
        wd_en = 1'b0;
        reg_rd = 1'b0;
        reg_wr = 1'b0;
        tick(3);
        pin_rst_n = 1'b1;
        tick();
    endtask

    // run a full count to overflow and check the pulse and the register
    task automatic t_overflow(logic oe_exp);
        wd_en = 1'b1;
        tick(256);
        chk("R3 no reset before edge 257", {7'd0, chip_rst}, 8'd0);
        tick();
        chk("R3 reset at edge 257", {7'd0, chip_rst}, 8'd1);
        chk("R6 ext output gating", {7'd0, ext_rst_n}, {7'd0, !oe_exp});
        tick(7);
        chk("R4 pulse still high at cycle 8", {7'd0, chip_rst}, 8'd1);
        tick();
        chk("R4 pulse ends after 8", {7'd0, chip_rst}, 8'd0);
        chk("R6 ext output released", {7'd0, ext_rst_n}, 8'd1);
        chk("R5 R7 flag set, enable kept", reg_rdata, {1'b1, oe_exp, 6'h3F});
        tick(300);
        chk("R4 no restart while enable held", {7'd0, chip_rst}, 8'd0);
        wd_en = 1'b0;
        tick();
    endtask

    task automatic t_reset_state();
        pin_reset();
        chk("R1 reset rdata", reg_rdata, 8'h3F);
        chk("R1 reset chip_rst", {7'd0, chip_rst}, 8'd0);
        chk("R1 reset ext_rst_n", {7'd0, ext_rst_n}, 8'd1);
    endtask

    task automatic t_write_bits();
        bus_write(8'h40);
        chk("R2 R8 oe written, reserved ones", reg_rdata, 8'h7F);
        bus_write(8'hC0);
        chk("R8 writing 1 to flag does not set", reg_rdata, 8'h7F);
    endtask

    task automatic t_clear_rules();
        logic [7:0] d;
        bus_write(8'h40);
        chk("R9 write 0 without read keeps flag", reg_rdata, 8'hFF);
        bus_read(d);
        chk("R9 read returns flag", d, 8'hFF);
        bus_write(8'hC0);
        chk("R8 write 1 does not clear", reg_rdata, 8'hFF);
        bus_write(8'h40);
        chk("R9 qualifier disarmed by write", reg_rdata, 8'hFF);
        bus_read(d);
        bus_write(8'h40);
        chk("R9 read then write 0 clears", reg_rdata, 8'h7F);
    endtask

    task automatic t_abort_count();
        wd_en = 1'b1;
        tick(200);
        wd_en = 1'b0;
        tick(2);
        chk("R11 no reset on drop", {7'd0, chip_rst}, 8'd0);
        wd_en = 1'b1;
        tick(256);
        chk("R11 count restarted from zero", {7'd0, chip_rst}, 8'd0);
        tick();
        chk("R11 overflow after full count", {7'd0, chip_rst}, 8'd1);
        tick(10);
        wd_en = 1'b0;
        tick();
    endtask

    task automatic t_collision();
        logic [7:0] d;
        wd_en = 1'b1;
        bus_read(d);
        chk("R10 flag set before collision", {7'd0, d[7]}, 8'd1);
        tick(255);
        reg_wr = 1'b1;
        reg_wdata = 8'h00;
        tick();
        reg_wr = 1'b0;
        chk("R10 overflow edge reached", {7'd0, chip_rst}, 8'd1);
        chk("R10 overflow wins over clear", {7'd0, reg_rdata[7]}, 8'd1);
        tick(10);
        wd_en = 1'b0;
        tick();
    endtask

    task automatic t_pin_clears();
        pin_reset();
        chk("R7 pin reset clears flag and enable", reg_rdata, 8'h3F);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_write_bits();
        t_overflow(1'b1);
        t_clear_rules();
        bus_write(8'h00);
        t_overflow(1'b0);
        t_abort_count();
        t_collision();
        t_pin_clears();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule